// File: doc/BRIEF.md
# Bus-Hold Block Transfer Engine

This block is a single-channel engine that moves a block of words between one peripheral and memory without help from the processor. Software first writes a start address, a word count and a control word that picks the direction and the handover mode. The engine is then armed. When the peripheral raises its request line, the engine asks the processor for the system bus with a hold request. It waits for the hold acknowledge, signals the peripheral with an acknowledge, and then runs one two-cycle strobe sequence per word. The address bus carries the current memory address during each word.

After each word the memory address steps up by one and the remaining count steps down by one. In block mode the engine keeps the bus until the last word. In cycle-stealing mode it gives the bus back after every word and asks again on the next request. When the count is used up, the engine drops its bus request and raises a completion interrupt together with a terminal-count status bit. Both stay set until software clears them.

Top module: `dma_hold_engine`

## Requirements
- R1: After reset, hrq, dack, memr, memw, ior, iow, irq and tc_flag are low and mem_addr is zero.
- R2: Writes with wr_sel=1 load the start address and writes with wr_sel=2 load the word count. A write with wr_sel=0 loads the control word: bit 0 set means memory-to-device, bit 1 set means cycle-stealing mode, bit 2 set starts the transfer, and bit 3 set clears the interrupt and the status bit. A start with a zero word count is ignored, and a later dreq then raises no hrq.
- R3: Once armed, a high dreq raises hrq one clock later. No strobe and no dack appear before hlda has been sampled high.
- R4: Throughout every word, dack is high and mem_addr carries that word's memory address. The first word uses the start address.
- R5: In a memory-to-device word, the first cycle has memr alone and the second has memr with iow. In a device-to-memory word, the first cycle has ior alone and the second has ior with memw.
- R6: After each word the address rises by one, wrapping at the address width. Exactly as many words as the programmed count are transferred.
- R7: In block mode, hrq stays high from the request to the last word. Words follow back to back, so hrq is high for 1 + 2×count cycles when hlda answers after one cycle.
- R8: In cycle-stealing mode, hrq falls after every word. The next word waits for dreq and a new hold handshake.
- R9: After the last word, hrq falls and irq and tc_flag rise. They stay high until a control write with bit 3 set.
- R10: While a transfer is armed or running, every register write is ignored. The address, count and mode in use do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 start address, 2 word count |
| wr_data | input | DATA_W | Register write data |
| dreq | input | 1 | Peripheral service request |
| hlda | input | 1 | Hold acknowledge from the processor |
| hrq | output | 1 | Hold request to the processor |
| dack | output | 1 | Acknowledge to the peripheral |
| mem_addr | output | ADDR_W | Memory address, zero while dack is low |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | Peripheral read strobe |
| iow | output | 1 | Peripheral write strobe |
| irq | output | 1 | Completion interrupt, sticky |
| tc_flag | output | 1 | Terminal-count status bit, sticky |

## Verification
A wrong state in the sequencer shows up within one cycle as a strobe without dack, a strobe pair in the wrong order, or hrq held or dropped in the wrong mode. The bench counts hold releases and the cycles spent with hrq high for each transfer. A wrong address or count copy shows up in the first word's mem_addr, or as a word too many or too few before irq rises. A broken write lockout shows up only later: the next transfer starts from the wrong address or in the wrong mode.

// File: rtl/dma_hold_pkg.sv
`timescale 1ns/1ps
package dma_hold_pkg;
   localparam int unsigned SEL_W = 2;
   localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
   localparam logic [SEL_W-1:0] SEL_BASE  = 2'd1;
   localparam logic [SEL_W-1:0] SEL_COUNT = 2'd2;

   localparam int unsigned CB_M2D   = 0;
   localparam int unsigned CB_STEAL = 1;
   localparam int unsigned CB_GO    = 2;
   localparam int unsigned CB_ACK   = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_REQ,
      ST_FIRST,
      ST_BOTH
   } seq_state_t;

   typedef struct packed {
      logic m2d;
      logic steal;
   } xfer_mode_t;
endpackage

// File: rtl/dma_hold_regs.sv
`timescale 1ns/1ps
module dma_hold_regs
   import dma_hold_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic              done_evt,
   output logic [ADDR_W-1:0] base_addr,
   output logic [CNT_W-1:0]  word_cnt,
   output xfer_mode_t        mode,
   output logic              arm,
   output logic              irq,
   output logic              tc_flag
);
   logic wr_ok;
   logic ctrl_wr;
   logic ack_req;

   assign wr_ok   = wr_en && !busy;
   assign ctrl_wr = wr_ok && (wr_sel == SEL_CTRL);
   assign ack_req = ctrl_wr && wr_data[CB_ACK];
   assign arm     = ctrl_wr && wr_data[CB_GO] && (word_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         word_cnt  <= '0;
         mode      <= '0;
      end else if (wr_ok) begin
         case (wr_sel)
            SEL_BASE:  base_addr <= wr_data[ADDR_W-1:0];
            SEL_COUNT: word_cnt  <= wr_data[CNT_W-1:0];
            SEL_CTRL: begin
               mode.m2d   <= wr_data[CB_M2D];
               mode.steal <= wr_data[CB_STEAL];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         tc_flag <= 1'b0;
      end else if (done_evt) begin
         irq     <= 1'b1;
         tc_flag <= 1'b1;
      end else if (ack_req) begin
         irq     <= 1'b0;
         tc_flag <= 1'b0;
      end
   end

   // R9: completion flags persist until software acknowledges them
   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack_req |=> irq);

   // R10: a write during a transfer leaves the programmed values untouched
   a_r10_busy_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(base_addr) && $stable(word_cnt) && $stable(mode));
endmodule

// File: rtl/dma_hold_walk.sv
`timescale 1ns/1ps
module dma_hold_walk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              last_word
);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   logic [CNT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         left     <= '0;
      end else if (load) begin
         cur_addr <= base_in;
         left     <= cnt_in;
      end else if (step) begin
         cur_addr <= cur_addr + ADDR_ONE;
         left     <= left - CNT_ONE;
      end
   end

   assign last_word = (left == CNT_ONE);

   // R6: a word is never issued once the remaining count is exhausted
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> left != '0);

   // R6: each completed word advances the memory address by one
   a_r6_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load |=> cur_addr == $past(cur_addr) + ADDR_ONE);
endmodule

// File: rtl/dma_hold_seq.sv
`timescale 1ns/1ps
module dma_hold_seq
   import dma_hold_pkg::*;
#(
   parameter bit SUPPORT_BLOCK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  xfer_mode_t mode,
   input  logic       dreq,
   input  logic       hlda,
   input  logic       last_word,
   output logic       hrq,
   output logic       dack,
   output logic       memr,
   output logic       memw,
   output logic       ior,
   output logic       iow,
   output logic       step,
   output logic       load,
   output logic       done_evt,
   output logic       busy
);
   seq_state_t state, nxt;
   logic steal_eff;

   generate
      if (SUPPORT_BLOCK) begin : g_both_modes
         assign steal_eff = mode.steal;
      end else begin : g_steal_only
         assign steal_eff = 1'b1;
      end
   endgenerate

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (arm)  nxt = ST_ARMED;
         ST_ARMED: if (dreq) nxt = ST_REQ;
         ST_REQ:   if (hlda) nxt = ST_FIRST;
         ST_FIRST: nxt = ST_BOTH;
         ST_BOTH: begin
            if (last_word)      nxt = ST_IDLE;
            else if (steal_eff) nxt = ST_ARMED;
            else                nxt = ST_FIRST;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign busy     = (state != ST_IDLE);
   assign load     = (state == ST_IDLE) && arm;
   assign hrq      = (state == ST_REQ) || (state == ST_FIRST) || (state == ST_BOTH);
   assign dack     = (state == ST_FIRST) || (state == ST_BOTH);
   assign step     = (state == ST_BOTH);
   assign done_evt = step && last_word;
   assign memr     = dack && mode.m2d;
   assign iow      = step && mode.m2d;
   assign ior      = dack && !mode.m2d;
   assign memw     = step && !mode.m2d;

   // R3: the peripheral acknowledge only starts after the grant was sampled
   a_r3_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dack) |-> $past(hlda));

   // R5: the second strobe of a word always follows a cycle of the first
   a_r5_order_m2d: assert property (@(posedge clk) disable iff (!rst_n)
      iow |-> memr && $past(memr) && !$past(iow));
   a_r5_order_d2m: assert property (@(posedge clk) disable iff (!rst_n)
      memw |-> ior && $past(ior) && !$past(memw));

   // R7: block mode keeps the bus between words
   a_r7_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
      step && !last_word && !steal_eff |=> hrq && dack);

   // R8: cycle stealing hands the bus back after every word
   a_r8_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
      step && steal_eff |=> !hrq);

   // R9: terminal count returns the bus
   a_r9_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> !hrq && !dack);
endmodule

// File: rtl/dma_hold_engine.sv
`timescale 1ns/1ps
module dma_hold_engine
   import dma_hold_pkg::*;
#(
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned CNT_W         = 16,
   parameter bit          SUPPORT_BLOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              dreq,
   input  logic              hlda,
   output logic              hrq,
   output logic              dack,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              memr,
   output logic              memw,
   output logic              ior,
   output logic              iow,
   output logic              irq,
   output logic              tc_flag
);
   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("ADDR_W must be between 1 and DATA_W");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must be between 1 and DATA_W");
      end
      if (DATA_W < 4) begin : g_bad_data_w
         $error("DATA_W must hold the four control bits");
      end
   endgenerate

   logic [ADDR_W-1:0] base_addr, cur_addr;
   logic [CNT_W-1:0]  word_cnt;
   xfer_mode_t        mode;
   logic arm, busy, done_evt, step, load, last_word;

   dma_hold_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .busy(busy), .done_evt(done_evt),
      .base_addr(base_addr), .word_cnt(word_cnt), .mode(mode),
      .arm(arm), .irq(irq), .tc_flag(tc_flag)
   );

   dma_hold_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .base_in(base_addr), .cnt_in(word_cnt),
      .cur_addr(cur_addr), .last_word(last_word)
   );

   dma_hold_seq #(.SUPPORT_BLOCK(SUPPORT_BLOCK)) u_seq (
      .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .dreq(dreq),
      .hlda(hlda), .last_word(last_word), .hrq(hrq), .dack(dack),
      .memr(memr), .memw(memw), .ior(ior), .iow(iow), .step(step),
      .load(load), .done_evt(done_evt), .busy(busy)
   );

   assign mem_addr = dack ? cur_addr : '0;

   // R4: the address bus holds still across the two cycles of a word
   a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      dack && !step |=> dack && $stable(mem_addr));

   // R1/R9: the bus is never driven while the engine has no hold
   a_r1_quiet_without_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hrq |-> !memr && !memw && !ior && !iow && mem_addr == '0);
endmodule

// File: tb/dma_hold_engine_test.sv
`timescale 1ns/1ps
module dma_hold_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        dreq = 1'b0;
   logic        hlda = 1'b0;
   logic        hrq, dack, memr, memw, ior, iow, irq, tc_flag;
   logic [15:0] mem_addr;

   int n_chk = 0;
   int n_err = 0;
   logic grant_en = 1'b1;
   int n_words, n_m2d, n_d2m, n_first, n_viol, n_rel, n_hrq_cyc;
   logic prev_hrq = 1'b0;
   logic [15:0] addr_log [0:15];

   always #5 clk = ~clk;

   dma_hold_engine uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .dreq(dreq), .hlda(hlda), .hrq(hrq), .dack(dack),
      .mem_addr(mem_addr), .memr(memr), .memw(memw), .ior(ior), .iow(iow),
      .irq(irq), .tc_flag(tc_flag)
   );

   // bus observer and processor grant model, both acting at falling edges
   initial begin
      forever begin
         @(negedge clk);
         if ((memr && iow) || (ior && memw)) begin
            if (n_words < 16) addr_log[n_words] = mem_addr;
            if (memr) n_m2d++; else n_d2m++;
            n_words++;
         end
         if (dack && (memr ^ ior) && !iow && !memw) n_first++;
         if ((memr || memw || ior || iow) && !(dack && hrq)) n_viol++;
         if (prev_hrq && !hrq) n_rel++;
         if (hrq) n_hrq_cyc++;
         prev_hrq = hrq;
         hlda <= hrq && grant_en;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clr_log();
      n_words = 0; n_m2d = 0; n_d2m = 0; n_first = 0;
      n_viol = 0; n_rel = 0; n_hrq_cyc = 0;
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_irq(input int limit);
      for (int i = 0; i < limit && !irq; i++) @(negedge clk);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 idle strobes", {hrq, dack, memr, memw, ior, iow, irq, tc_flag}, 8'h00);
      chk("R1 idle address", mem_addr, 16'h0000);
   endtask

   task automatic t_block();
      clr_log();
      wreg(2'd1, 16'h0100);
      wreg(2'd2, 16'd4);
      wreg(2'd0, 16'b0101);
      dreq = 1'b1;
      wait_irq(100);
      dreq = 1'b0;
      chk("R6 block word count", n_words, 4);
      for (int i = 0; i < 4; i++) chk("R4 block address", addr_log[i], 16'h0100 + i);
      chk("R5 memory-to-device pairs", n_m2d, 4);
      chk("R5 first-strobe cycles", n_first, 4);
      chk("R7 single release", n_rel, 1);
      chk("R7 hold cycles", n_hrq_cyc, 9);
      chk("R3 strobes only under hold", n_viol, 0);
      chk("R9 flags set", {irq, tc_flag, hrq}, 3'b110);
   endtask

   task automatic t_sticky();
      repeat (20) @(negedge clk);
      chk("R9 flags persist", {irq, tc_flag}, 2'b11);
      wreg(2'd0, 16'b1000);
      chk("R9 flags cleared", {irq, tc_flag}, 2'b00);
   endtask

   task automatic t_grant_wait();
      clr_log();
      wreg(2'd1, 16'h0200);
      wreg(2'd2, 16'd1);
      wreg(2'd0, 16'b0101);
      repeat (4) @(negedge clk);
      chk("R3 no request without dreq", hrq, 1'b0);
      grant_en = 1'b0;
      dreq = 1'b1;
      @(negedge clk);
      chk("R3 request after dreq", hrq, 1'b1);
      repeat (8) @(negedge clk);
      chk("R3 no dack before grant", {dack, memr, iow}, 3'b000);
      grant_en = 1'b1;
      wait_irq(40);
      dreq = 1'b0;
      chk("R3 one word after grant", n_words, 1);
      chk("R4 granted address", addr_log[0], 16'h0200);
      wreg(2'd0, 16'b1000);
   endtask

   task automatic t_steal();
      clr_log();
      wreg(2'd1, 16'hFFFE);
      wreg(2'd2, 16'd3);
      wreg(2'd0, 16'b0110);
      dreq = 1'b1;
      for (int i = 0; i < 50 && n_words < 1; i++) begin
         @(negedge clk); #1;
      end
      dreq = 1'b0;
      repeat (10) @(negedge clk);
      chk("R8 waits for dreq", n_words, 1);
      chk("R8 bus released between words", hrq, 1'b0);
      dreq = 1'b1;
      wait_irq(100);
      dreq = 1'b0;
      chk("R6 steal word count", n_words, 3);
      chk("R6 address wrap 0", addr_log[0], 16'hFFFE);
      chk("R6 address wrap 1", addr_log[1], 16'hFFFF);
      chk("R6 address wrap 2", addr_log[2], 16'h0000);
      chk("R5 device-to-memory pairs", n_d2m, 3);
      chk("R8 release per word", n_rel, 3);
      wreg(2'd0, 16'b1000);
   endtask

   task automatic t_busy_ignore();
      clr_log();
      wreg(2'd1, 16'h0300);
      wreg(2'd2, 16'd2);
      wreg(2'd0, 16'b0101);
      wreg(2'd1, 16'h5555);
      wreg(2'd2, 16'd9);
      wreg(2'd0, 16'b0010);
      dreq = 1'b1;
      wait_irq(100);
      dreq = 1'b0;
      chk("R10 count kept", n_words, 2);
      chk("R10 address kept", addr_log[0], 16'h0300);
      chk("R10 mode kept", {n_rel[7:0], n_m2d[7:0]}, 16'h0102);
      wreg(2'd0, 16'b1000);
   endtask

   task automatic t_zero_count();
      clr_log();
      wreg(2'd2, 16'd0);
      wreg(2'd0, 16'b0101);
      dreq = 1'b1;
      repeat (10) @(negedge clk);
      chk("R2 zero count not armed", {hrq, irq}, 2'b00);
      chk("R2 zero count no words", n_words, 0);
      dreq = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
   end

   initial begin
      clr_log();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_block();
      t_sticky();
      t_grant_wait();
      t_steal();
      t_busy_ignore();
      t_zero_count();
      report();
   end
endmodule